// File: doc/BRIEF.md
# Register Rename Tag Table

This block holds the architectural register state of a tag-based out-of-order core. Each register keeps a data value and a producer tag. A tag of zero is the null tag and means the stored value is current; any other tag names the execution station that will produce the register's next value. The issue stage presents two source register indices and receives, for each, either a ready value or the tag of the station it must wait for. In the same cycle it may rename one destination register to the issuing station's tag.

When a station completes, it drives its tag and result onto the broadcast port. Every register still naming that tag takes the value and returns to the null tag. A register that has since been renamed to a newer producer keeps its value and tag, so a slow older writer cannot overwrite the newer result. A source read in the same cycle as a matching broadcast is forwarded so that the issuing instruction never misses that result. A preload port writes values directly, so that a test or boot sequence can set the initial register contents.

Top module: `rrt_table`

## Requirements
- R1: After reset every register reads as ready with value zero and a null tag.
- R2: A source read of a register with a null tag gives ready=1, the stored value and tag output zero; a read of a register with a non-null tag (and no matching broadcast) gives ready=0, value output zero and the producer tag.
- R3: An issue with a destination writes the issuing tag into that register on the next clock edge, replacing any non-null tag it held.
- R4: A broadcast with a non-null tag equal to a register's tag stores the broadcast value in that register and sets its tag to null on the next clock edge.
- R5: A broadcast whose tag differs from a register's tag leaves that register's value and tag unchanged (a renamed register ignores an older producer).
- R6: One broadcast updates every register holding the broadcast tag in the same edge.
- R7: When an issue renames a register in the same cycle that a matching broadcast would clear it, the register ends with the new issue tag.
- R8: A source read whose register tag equals the tag broadcast in that cycle gives ready=1, the broadcast value and tag zero.
- R9: A preload writes its value into the indexed register and sets its tag to null on the next edge; a preload takes priority over a same-cycle broadcast value, and a same-cycle issue tag still takes priority over the cleared tag.
- R10: A source read in the cycle that renames the same register returns the register's state before the rename.
- R11: A broadcast with the valid bit low, or with the null tag, changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Rename the destination register this cycle |
| iss_dst | input | IDX_W | Destination register index |
| iss_tag | input | TAG_W | Tag of the issuing station (must be non-null) |
| iss_src_a | input | IDX_W | First source register index |
| iss_src_b | input | IDX_W | Second source register index |
| bc_valid | input | 1 | Result broadcast present |
| bc_tag | input | TAG_W | Tag of the broadcasting station |
| bc_value | input | DATA_W | Broadcast result |
| pre_valid | input | 1 | Preload write enable |
| pre_idx | input | IDX_W | Preload register index |
| pre_value | input | DATA_W | Preload value |
| a_ready | output | 1 | First source value is available |
| a_value | output | DATA_W | First source value (zero when not ready) |
| a_tag | output | TAG_W | First source producer tag (zero when ready) |
| b_ready | output | 1 | Second source value is available |
| b_value | output | DATA_W | Second source value (zero when not ready) |
| b_tag | output | TAG_W | Second source producer tag (zero when ready) |

## Verification
The assertions watch every register on every cycle: a rename always lands the issuing tag, a matching broadcast always clears the tag with the right value, a register not addressed by any matching update stays stable, and the source outputs keep the ready/value/tag encoding and forward a same-cycle broadcast. Reset contents, shared tags cleared by one broadcast, and the stale-producer sequence in which an older station finishes after its register was renamed are shown by the bench's directed scenarios, alongside random traffic checked against a bench model of the register state.

// File: rtl/rrt_pkg.sv
package rrt_pkg;

    // Source of a register's next tag, in priority order high to low:
    // issue rename, preload clear, broadcast capture clear, hold.
    typedef enum logic [1:0] {
        TSEL_HOLD    = 2'd0,
        TSEL_CAPTURE = 2'd1,
        TSEL_PRELOAD = 2'd2,
        TSEL_ISSUE   = 2'd3
    } rrt_tsel_e;

    // Source of a register's next value.
    typedef enum logic [1:0] {
        VSEL_HOLD    = 2'd0,
        VSEL_CAPTURE = 2'd1,
        VSEL_PRELOAD = 2'd2
    } rrt_vsel_e;

endpackage

// File: rtl/rrt_entry.sv
module rrt_entry
    import rrt_pkg::*;
#(
    parameter int TAG_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_hit,
    input  logic [TAG_W-1:0]  iss_tag,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_value,
    input  logic              pre_hit,
    input  logic [DATA_W-1:0] pre_value,
    output logic [TAG_W-1:0]  tag_q,
    output logic [DATA_W-1:0] val_q
);

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] val;
    } ent_t;

    ent_t      ent_d, ent_q;
    rrt_tsel_e tsel;
    rrt_vsel_e vsel;
    logic      capture;

    always_comb begin
        // Only a pending register can capture; a null broadcast tag never matches.
        capture = bc_valid && (bc_tag != '0) && (ent_q.tag == bc_tag);

        if (iss_hit)       tsel = TSEL_ISSUE;
        else if (pre_hit)  tsel = TSEL_PRELOAD;
        else if (capture)  tsel = TSEL_CAPTURE;
        else               tsel = TSEL_HOLD;

        if (pre_hit)       vsel = VSEL_PRELOAD;
        else if (capture)  vsel = VSEL_CAPTURE;
        else               vsel = VSEL_HOLD;

        ent_d = ent_q;
        unique case (tsel)
            TSEL_ISSUE:   ent_d.tag = iss_tag;
            TSEL_PRELOAD: ent_d.tag = '0;
            TSEL_CAPTURE: ent_d.tag = '0;
            default:      ent_d.tag = ent_q.tag;
        endcase
        unique case (vsel)
            VSEL_PRELOAD: ent_d.val = pre_value;
            VSEL_CAPTURE: ent_d.val = bc_value;
            default:      ent_d.val = ent_q.val;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ent_q <= '0;
        else        ent_q <= ent_d;
    end

    assign tag_q = ent_q.tag;
    assign val_q = ent_q.val;

endmodule

// File: rtl/rrt_src_port.sv
module rrt_src_port #(
    parameter int NUM_REGS = 16,
    parameter int TAG_W    = 4,
    parameter int DATA_W   = 32,
    parameter int IDX_W    = 4
) (
    input  logic [NUM_REGS-1:0][TAG_W-1:0]  tags,
    input  logic [NUM_REGS-1:0][DATA_W-1:0] vals,
    input  logic [IDX_W-1:0]                idx,
    input  logic                            bc_valid,
    input  logic [TAG_W-1:0]                bc_tag,
    input  logic [DATA_W-1:0]               bc_value,
    output logic                            rdy,
    output logic [DATA_W-1:0]               value,
    output logic [TAG_W-1:0]                tag
);

    logic [TAG_W-1:0]  sel_tag;
    logic [DATA_W-1:0] sel_val;

    always_comb begin
        sel_tag = tags[idx];
        sel_val = vals[idx];
        if (sel_tag == '0) begin
            rdy   = 1'b1;
            value = sel_val;
            tag   = '0;
        end else if (bc_valid && (sel_tag == bc_tag)) begin
            // forward the result arriving this cycle
            rdy   = 1'b1;
            value = bc_value;
            tag   = '0;
        end else begin
            rdy   = 1'b0;
            value = '0;
            tag   = sel_tag;
        end
    end

endmodule

// File: rtl/rrt_table.sv
module rrt_table
    import rrt_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int TAG_W    = 4,
    parameter int DATA_W   = 32,
    localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic [IDX_W-1:0]  iss_dst,
    input  logic [TAG_W-1:0]  iss_tag,
    input  logic [IDX_W-1:0]  iss_src_a,
    input  logic [IDX_W-1:0]  iss_src_b,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_value,
    input  logic              pre_valid,
    input  logic [IDX_W-1:0]  pre_idx,
    input  logic [DATA_W-1:0] pre_value,
    output logic              a_ready,
    output logic [DATA_W-1:0] a_value,
    output logic [TAG_W-1:0]  a_tag,
    output logic              b_ready,
    output logic [DATA_W-1:0] b_value,
    output logic [TAG_W-1:0]  b_tag
);

    logic [NUM_REGS-1:0][TAG_W-1:0]  ent_tag;
    logic [NUM_REGS-1:0][DATA_W-1:0] ent_val;
    logic [NUM_REGS-1:0]             iss_hit;
    logic [NUM_REGS-1:0]             pre_hit;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_ent
        assign iss_hit[i] = iss_valid && (iss_dst == IDX_W'(i));
        assign pre_hit[i] = pre_valid && (pre_idx == IDX_W'(i));

        rrt_entry #(
            .TAG_W  (TAG_W),
            .DATA_W (DATA_W)
        ) u_entry (
            .clk       (clk),
            .rst_n     (rst_n),
            .iss_hit   (iss_hit[i]),
            .iss_tag   (iss_tag),
            .bc_valid  (bc_valid),
            .bc_tag    (bc_tag),
            .bc_value  (bc_value),
            .pre_hit   (pre_hit[i]),
            .pre_value (pre_value),
            .tag_q     (ent_tag[i]),
            .val_q     (ent_val[i])
        );
    end

    rrt_src_port #(
        .NUM_REGS (NUM_REGS),
        .TAG_W    (TAG_W),
        .DATA_W   (DATA_W),
        .IDX_W    (IDX_W)
    ) u_src_a (
        .tags     (ent_tag),
        .vals     (ent_val),
        .idx      (iss_src_a),
        .bc_valid (bc_valid),
        .bc_tag   (bc_tag),
        .bc_value (bc_value),
        .rdy      (a_ready),
        .value    (a_value),
        .tag      (a_tag)
    );

    rrt_src_port #(
        .NUM_REGS (NUM_REGS),
        .TAG_W    (TAG_W),
        .DATA_W   (DATA_W),
        .IDX_W    (IDX_W)
    ) u_src_b (
        .tags     (ent_tag),
        .vals     (ent_val),
        .idx      (iss_src_b),
        .bc_valid (bc_valid),
        .bc_tag   (bc_tag),
        .bc_value (bc_value),
        .rdy      (b_ready),
        .value    (b_value),
        .tag      (b_tag)
    );

endmodule

// File: rtl/rrt_table_chk.sv
module rrt_table_chk #(
    parameter int NUM_REGS = 16,
    parameter int TAG_W    = 4,
    parameter int DATA_W   = 32,
    parameter int IDX_W    = 4
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            iss_valid,
    input logic [IDX_W-1:0]                iss_dst,
    input logic [TAG_W-1:0]                iss_tag,
    input logic [IDX_W-1:0]                iss_src_a,
    input logic                            bc_valid,
    input logic [TAG_W-1:0]                bc_tag,
    input logic [DATA_W-1:0]               bc_value,
    input logic                            pre_valid,
    input logic [IDX_W-1:0]                pre_idx,
    input logic [DATA_W-1:0]               pre_value,
    input logic                            a_ready,
    input logic [DATA_W-1:0]               a_value,
    input logic [TAG_W-1:0]                a_tag,
    input logic                            b_ready,
    input logic [DATA_W-1:0]               b_value,
    input logic [TAG_W-1:0]                b_tag,
    input logic [NUM_REGS-1:0][TAG_W-1:0]  ent_tag,
    input logic [NUM_REGS-1:0][DATA_W-1:0] ent_val
);

    // R2: source output encoding
    p_src_a_enc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        a_ready ? (a_tag == '0) : (a_value == '0 && a_tag != '0));
    p_src_b_enc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        b_ready ? (b_tag == '0) : (b_value == '0 && b_tag != '0));

    // R8: same-cycle broadcast forwarded to a waiting source
    p_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bc_valid && bc_tag != '0 && ent_tag[iss_src_a] == bc_tag)
        |-> (a_ready && a_value == bc_value));

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        // R3, R7: a rename always wins the tag
        p_rename_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (iss_valid && iss_dst == IDX_W'(i)) |=> (ent_tag[i] == $past(iss_tag)));

        // R4: matching broadcast captured
        p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (bc_valid && bc_tag != '0 && ent_tag[i] == bc_tag
             && !(iss_valid && iss_dst == IDX_W'(i))
             && !(pre_valid && pre_idx == IDX_W'(i)))
            |=> (ent_tag[i] == '0 && ent_val[i] == $past(bc_value)));

        // R5, R11: no matching update leaves the register alone
        p_stale_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (!(bc_valid && bc_tag != '0 && ent_tag[i] == bc_tag)
             && !(iss_valid && iss_dst == IDX_W'(i))
             && !(pre_valid && pre_idx == IDX_W'(i)))
            |=> ($stable(ent_tag[i]) && $stable(ent_val[i])));

        // R9: preload stores its value
        p_preload_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (pre_valid && pre_idx == IDX_W'(i)) |=> (ent_val[i] == $past(pre_value)));
    end

endmodule

bind rrt_table rrt_table_chk #(
    .NUM_REGS (NUM_REGS),
    .TAG_W    (TAG_W),
    .DATA_W   (DATA_W),
    .IDX_W    (IDX_W)
) u_rrt_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .iss_valid (iss_valid),
    .iss_dst   (iss_dst),
    .iss_tag   (iss_tag),
    .iss_src_a (iss_src_a),
    .bc_valid  (bc_valid),
    .bc_tag    (bc_tag),
    .bc_value  (bc_value),
    .pre_valid (pre_valid),
    .pre_idx   (pre_idx),
    .pre_value (pre_value),
    .a_ready   (a_ready),
    .a_value   (a_value),
    .a_tag     (a_tag),
    .b_ready   (b_ready),
    .b_value   (b_value),
    .b_tag     (b_tag),
    .ent_tag   (ent_tag),
    .ent_val   (ent_val)
);

// File: tb/test_rrt_table.sv
`timescale 1ns/1ps
module test_rrt_table;

    localparam int NR = 16;
    localparam int TW = 4;
    localparam int DW = 32;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          iss_valid;
    logic [IW-1:0] iss_dst, iss_src_a, iss_src_b;
    logic [TW-1:0] iss_tag;
    logic          bc_valid;
    logic [TW-1:0] bc_tag;
    logic [DW-1:0] bc_value;
    logic          pre_valid;
    logic [IW-1:0] pre_idx;
    logic [DW-1:0] pre_value;
    logic          a_ready, b_ready;
    logic [DW-1:0] a_value, b_value;
    logic [TW-1:0] a_tag, b_tag;

    int n_vec = 0;
    int n_bad = 0;

    logic [TW-1:0] ref_tag [NR];
    logic [DW-1:0] ref_val [NR];

    always #2 clk = ~clk;

    rrt_table #(.NUM_REGS(NR), .TAG_W(TW), .DATA_W(DW)) i_rrt_table (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_dst(iss_dst), .iss_tag(iss_tag),
        .iss_src_a(iss_src_a), .iss_src_b(iss_src_b),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_value(bc_value),
        .pre_valid(pre_valid), .pre_idx(pre_idx), .pre_value(pre_value),
        .a_ready(a_ready), .a_value(a_value), .a_tag(a_tag),
        .b_ready(b_ready), .b_value(b_value), .b_tag(b_tag)
    );

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got still running, expected finished");
        summary();
        $finish;
    end

    // Expected source read from the bench model (R2, R8)
    task automatic exp_read(input logic [IW-1:0] idx, input logic bv, input logic [TW-1:0] bt,
                            input logic [DW-1:0] bval, output logic r, output logic [DW-1:0] v,
                            output logic [TW-1:0] t);
        if (ref_tag[idx] == '0) begin
            r = 1'b1; v = ref_val[idx]; t = '0;
        end else if (bv && ref_tag[idx] == bt) begin
            r = 1'b1; v = bval; t = '0;
        end else begin
            r = 1'b0; v = '0; t = ref_tag[idx];
        end
    endtask

    task automatic check_port(input string req, input string pn, input logic r,
                              input logic [DW-1:0] v, input logic [TW-1:0] t, input logic er,
                              input logic [DW-1:0] ev, input logic [TW-1:0] et);
        n_vec++;
        if (r !== er || v !== ev || t !== et) begin
            n_bad++;
            $display("FAIL %s port %s: got ready=%0d value=%h tag=%0d, expected ready=%0d value=%h tag=%0d",
                     req, pn, r, v, t, er, ev, et);
        end
    endtask

    // One cycle: drive after the falling edge, check reads, update model at rising edge.
    task automatic step(input string req, input logic iv, input logic [IW-1:0] dst,
                        input logic [TW-1:0] itag, input logic [IW-1:0] sa, input logic [IW-1:0] sb,
                        input logic bv, input logic [TW-1:0] bt, input logic [DW-1:0] bval,
                        input logic pv, input logic [IW-1:0] pidx, input logic [DW-1:0] pval);
        logic          er;
        logic [DW-1:0] ev;
        logic [TW-1:0] et;
        iss_valid = iv; iss_dst = dst; iss_tag = itag; iss_src_a = sa; iss_src_b = sb;
        bc_valid = bv; bc_tag = bt; bc_value = bval;
        pre_valid = pv; pre_idx = pidx; pre_value = pval;
        #1;
        exp_read(sa, bv, bt, bval, er, ev, et);
        check_port(req, "a", a_ready, a_value, a_tag, er, ev, et);
        exp_read(sb, bv, bt, bval, er, ev, et);
        check_port(req, "b", b_ready, b_value, b_tag, er, ev, et);
        @(posedge clk);
        for (int i = 0; i < NR; i++) begin
            if (pv && pidx == IW'(i)) begin
                ref_val[i] = pval; ref_tag[i] = '0;
            end else if (bv && bt != '0 && ref_tag[i] == bt) begin
                ref_val[i] = bval; ref_tag[i] = '0;
            end
            if (iv && dst == IW'(i)) ref_tag[i] = itag;
        end
        @(negedge clk);
    endtask

    task automatic idle_read(input string req, input logic [IW-1:0] sa, input logic [IW-1:0] sb);
        step(req, 1'b0, '0, '0, sa, sb, 1'b0, '0, '0, 1'b0, '0, '0);
    endtask

    task automatic preload(input logic [IW-1:0] idx, input logic [DW-1:0] v);
        step("R9", 1'b0, '0, '0, idx, idx, 1'b0, '0, '0, 1'b1, idx, v);
    endtask

    initial begin
        void'($urandom(32'd2718));
        rst_n = 1'b0;
        iss_valid = 0; iss_dst = 0; iss_tag = 0; iss_src_a = 0; iss_src_b = 0;
        bc_valid = 0; bc_tag = 0; bc_value = 0; pre_valid = 0; pre_idx = 0; pre_value = 0;
        for (int i = 0; i < NR; i++) begin ref_tag[i] = '0; ref_val[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: every register ready, zero
        for (int i = 0; i < NR; i += 2) idle_read("R1", IW'(i), IW'(i + 1));

        // R9: preload sources; read back
        for (int i = 0; i < NR; i++) preload(IW'(i), 32'h100 + DW'(i));
        for (int i = 0; i < NR; i += 2) idle_read("R9", IW'(i), IW'(i + 1));

        // R3: rename reg1 to tag 5, then rename again to tag 9 (R5 scenario setup)
        step("R3", 1'b1, 4'd1, 4'd5, 4'd2, 4'd3, 1'b0, '0, '0, 1'b0, '0, '0);
        idle_read("R3", 4'd1, 4'd1);
        // R10: source reads reg1 while it is renamed: sees tag 5
        step("R10", 1'b1, 4'd1, 4'd9, 4'd1, 4'd4, 1'b0, '0, '0, 1'b0, '0, '0);
        idle_read("R2", 4'd1, 4'd2);
        // R8: broadcast tag 9 while reading reg1: forwarded
        step("R8", 1'b0, '0, '0, 4'd1, 4'd0, 1'b1, 4'd9, 32'd12, 1'b0, '0, '0);
        idle_read("R4", 4'd1, 4'd1);
        // R5: older producer tag 5 finishes; reg1 keeps 12
        step("R5", 1'b0, '0, '0, 4'd2, 4'd3, 1'b1, 4'd5, 32'd6, 1'b0, '0, '0);
        idle_read("R5", 4'd1, 4'd1);

        // R6: tag 4 on regs 5 and 6, one broadcast clears both
        step("R6", 1'b1, 4'd5, 4'd4, 4'd5, 4'd6, 1'b0, '0, '0, 1'b0, '0, '0);
        step("R6", 1'b1, 4'd6, 4'd4, 4'd5, 4'd6, 1'b0, '0, '0, 1'b0, '0, '0);
        idle_read("R6", 4'd5, 4'd6);
        step("R6", 1'b0, '0, '0, 4'd7, 4'd8, 1'b1, 4'd4, 32'hCAFE, 1'b0, '0, '0);
        idle_read("R6", 4'd5, 4'd6);

        // R7: reg7 tag 3; issue tag 11 to reg7 while tag 3 broadcasts
        step("R7", 1'b1, 4'd7, 4'd3, 4'd0, 4'd0, 1'b0, '0, '0, 1'b0, '0, '0);
        step("R7", 1'b1, 4'd7, 4'd11, 4'd7, 4'd0, 1'b1, 4'd3, 32'hBEEF, 1'b0, '0, '0);
        idle_read("R7", 4'd7, 4'd7);

        // R11: reg8 tag 6; broadcast tag 6 with valid low, then tag 0 with valid high
        step("R11", 1'b1, 4'd8, 4'd6, 4'd0, 4'd0, 1'b0, '0, '0, 1'b0, '0, '0);
        step("R11", 1'b0, '0, '0, 4'd8, 4'd9, 1'b0, 4'd6, 32'h5555, 1'b0, '0, '0);
        idle_read("R11", 4'd8, 4'd9);
        step("R11", 1'b0, '0, '0, 4'd9, 4'd10, 1'b1, 4'd0, 32'h7777, 1'b0, '0, '0);
        idle_read("R11", 4'd9, 4'd10);

        // R9: preload and matching broadcast same reg same cycle; preload value wins
        step("R9", 1'b1, 4'd10, 4'd2, 4'd0, 4'd0, 1'b0, '0, '0, 1'b0, '0, '0);
        step("R9", 1'b0, '0, '0, 4'd0, 4'd0, 1'b1, 4'd2, 32'hAAAA, 1'b1, 4'd10, 32'h1234);
        idle_read("R9", 4'd10, 4'd10);

        // Random traffic checked against the model (R2..R11)
        for (int n = 0; n < 3000; n++) begin
            logic          iv, bv, pv;
            logic [IW-1:0] dst, sa, sb, pidx;
            logic [TW-1:0] itag, bt;
            logic [DW-1:0] bval, pval;
            iv   = ($urandom_range(0, 99) < 50);
            dst  = IW'($urandom_range(0, NR - 1));
            itag = TW'($urandom_range(1, (1 << TW) - 1));
            sa   = IW'($urandom_range(0, NR - 1));
            sb   = IW'($urandom_range(0, NR - 1));
            bv   = ($urandom_range(0, 99) < 60);
            bt   = ($urandom_range(0, 99) < 75) ? ref_tag[$urandom_range(0, NR - 1)]
                                                 : TW'($urandom_range(0, (1 << TW) - 1));
            bval = DW'($urandom);
            pv   = ($urandom_range(0, 99) < 8);
            pidx = IW'($urandom_range(0, NR - 1));
            pval = DW'($urandom);
            step("R2", iv, dst, itag, sa, sb, bv, bt, bval, pv, pidx, pval);
        end

        summary();
        $finish;
    end

endmodule